// File: doc/BRIEF.md
# PLL Recalibration Sequencer

This block drives a fixed recalibration routine on a PLL through the PLL's memory-mapped configuration port. A single-cycle start pulse launches the routine. The block first switches the PLL onto its internal feedback path. It then requests a calibration run and polls a status register until the calibration engine reports that it is idle. Next it waits for the PLL to lock, returns the PLL to its external feedback path, and waits for lock a second time. Finally it pulses done.

Every register change is a masked read-modify-write. Each one reads the register, waits for the read to complete, and writes back the same value with only the one target bit forced. The bus master issues one command at a time and holds it steady while the slave stalls with waitrequest.

A programmable cycle limit bounds each status poll and each lock wait. When the limit expires, the sequencer stops in an error state and raises an error flag. The next start pulse clears the flag and reruns the routine.

Top module: `pll_recal_seq`

## Requirements
- R1: The first bus write goes to address 0x126 and carries the value read from 0x126 with bit 0 set to 1; every other bit is unchanged.
- R2: The next two writes go to 0x100 and then to 0x000. Each carries the value read from its own address with bit 0 set; every other bit is unchanged.
- R3: After the write to 0x000, the block reads 0x280 repeatedly. It does not continue while bit 1 of that read is 1, and it stops polling on the first read that returns bit 1 = 0.
- R4: After the poll ends, no further access is issued until lock_i is high.
- R5: The fourth write goes to 0x126 and carries the value read from 0x126 with bit 0 cleared to 0; every other bit is unchanged.
- R6: After that write, done_o pulses high for exactly one cycle, and only once lock_i has been seen high again. busy_o is low in the following cycle.
- R7: Every register update is one read of an address followed by one write to the same address. Each run therefore performs exactly four reads of addresses other than 0x280. Read and write are never high together.
- R8: While bus_wait_i is high during a command, the command bits, the address and the write data keep their values.
- R9: busy_o goes high in the cycle after an accepted start and stays high up to and including the done cycle. A start pulse while busy_o is high causes no further access and no second done.
- R10: When a poll or a lock wait lasts beyond tmo_limit_i cycles, the block enters an error state. In that state err_o is high, busy_o is low and no bus command is issued. The next start clears err_o and restarts the routine.
- R11: While rst_ni is low, busy_o, done_o, err_o, bus_rd_o and bus_wr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| tmo_limit_i | input | TMO_W | Cycle limit for each poll or lock wait |
| lock_i | input | 1 | PLL lock indication, synchronous to clk_i |
| bus_addr_o | output | ADDR_W | Configuration port address |
| bus_rd_o | output | 1 | Read command |
| bus_wr_o | output | 1 | Write command |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid when a read is not stalled |
| bus_wait_i | input | 1 | Slave stall; the current command is held |
| busy_o | output | 1 | Routine in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout error flag |

## Verification
The bench preloads the feedback and request registers with values that have other bits set, including one run where bit 0 of the feedback register is already 1. A design that wrote constants instead of merging with the read value, or that toggled the bit instead of forcing it, would produce wrong write data.

The slave model stalls both the read and the write phase for several cycles. A master that changed address or data mid-stall, or that skipped the read, would break the recorded transfer log. Lock is made to arrive late after each feedback switch, so a design that ignored lock would issue the final update or done too early.

Calibration that never finishes and a lock that never returns drive the two timeout paths. After each, the bench checks that the bus stays silent and that a fresh start recovers. A second start pulse during a run must leave the run unaffected.

// File: rtl/pll_recal_pkg.sv
package pll_recal_pkg;
  localparam int unsigned REG_FB_SEL   = 'h126;
  localparam int unsigned REG_CAL_REQ  = 'h100;
  localparam int unsigned REG_CAL_GO   = 'h000;
  localparam int unsigned REG_CAL_STAT = 'h280;
  localparam int unsigned FB_BIT       = 0;
  localparam int unsigned REQ_BIT      = 0;
  localparam int unsigned STAT_BUSY    = 1;

  typedef enum logic [1:0] {OP_READ, OP_SET, OP_CLR} rmw_op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_WR} bus_ph_e;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FB_INT, ST_REQ, ST_GO, ST_POLL,
    ST_LOCK1, ST_FB_EXT, ST_LOCK2, ST_DONE, ST_ERR
  } seq_state_e;
endpackage

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/pll_rmw_master.sv
module pll_rmw_master
  import pll_recal_pkg::*;
#(
  parameter  int unsigned ADDR_W = 12,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  rmw_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              ack_o,
  output logic              rbit_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_wait_i
);
  bus_ph_e           ph_q;
  rmw_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] wdata_q, mask, merged;

  assign mask   = {{(DATA_W-1){1'b0}}, 1'b1} << bit_q;
  assign merged = (op_q == OP_CLR) ? (bus_rdata_i & ~mask) : (bus_rdata_i | mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      bit_q   <= '0;
      wdata_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (req_i) begin
          ph_q   <= PH_RD;
          op_q   <= op_i;
          addr_q <= addr_i;
          bit_q  <= bit_i;
        end
        PH_RD: if (!bus_wait_i) begin
          if (op_q == OP_READ) ph_q <= PH_IDLE;
          else begin
            ph_q    <= PH_WR;
            wdata_q <= merged;
          end
        end
        PH_WR: if (!bus_wait_i) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign bus_rd_o    = (ph_q == PH_RD);
  assign bus_wr_o    = (ph_q == PH_WR);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign rbit_o      = bus_rdata_i[bit_q];
  assign ack_o       = !bus_wait_i && ((bus_rd_o && op_q == OP_READ) || bus_wr_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) && bus_wait_i |=>
      bus_rd_o == $past(bus_rd_o) && bus_wr_o == $past(bus_wr_o) &&
      bus_addr_o == $past(bus_addr_o) && bus_wdata_o == $past(bus_wdata_o));

  assert_read_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_wr_o) |-> $past(bus_rd_o) && $past(bus_addr_o) == bus_addr_o);
endmodule

// File: rtl/pll_recal_seq.sv
module pll_recal_seq
  import pll_recal_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              lock_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_wait_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  seq_state_e        state_q, state_d;
  logic              req, ack, rbit, expired;
  rmw_op_e           op;
  logic [ADDR_W-1:0] addr;
  logic [BIT_W-1:0]  bsel;

  always_comb begin
    req  = 1'b1;
    op   = OP_SET;
    addr = '0;
    bsel = '0;
    unique case (state_q)
      ST_FB_INT: begin addr = ADDR_W'(REG_FB_SEL);  bsel = BIT_W'(FB_BIT); end
      ST_REQ:    begin addr = ADDR_W'(REG_CAL_REQ); bsel = BIT_W'(REQ_BIT); end
      ST_GO:     begin addr = ADDR_W'(REG_CAL_GO);  bsel = BIT_W'(REQ_BIT); end
      ST_POLL:   begin addr = ADDR_W'(REG_CAL_STAT); bsel = BIT_W'(STAT_BUSY); op = OP_READ; end
      ST_FB_EXT: begin addr = ADDR_W'(REG_FB_SEL);  bsel = BIT_W'(FB_BIT); op = OP_CLR; end
      default:   req = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_ERR: if (start_i) state_d = ST_FB_INT;
      ST_FB_INT: if (ack) state_d = ST_REQ;
      ST_REQ:    if (ack) state_d = ST_GO;
      ST_GO:     if (ack) state_d = ST_POLL;
      ST_POLL:   if (ack) begin
        if (!rbit)        state_d = ST_LOCK1;
        else if (expired) state_d = ST_ERR;
      end
      ST_LOCK1:  if (lock_i) state_d = ST_FB_EXT; else if (expired) state_d = ST_ERR;
      ST_FB_EXT: if (ack) state_d = ST_LOCK2;
      ST_LOCK2:  if (lock_i) state_d = ST_DONE;   else if (expired) state_d = ST_ERR;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  pll_rmw_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i, .rst_ni,
    .req_i(req), .op_i(op), .addr_i(addr), .bit_i(bsel),
    .ack_o(ack), .rbit_o(rbit),
    .bus_addr_o, .bus_rd_o, .bus_wr_o, .bus_wdata_o,
    .bus_rdata_i, .bus_wait_i
  );

  pll_wait_timer #(.CNT_W(TMO_W)) u_tmr (
    .clk_i, .rst_ni,
    .clr_i(state_d != state_q),
    .limit_i(tmo_limit_i),
    .expired_o(expired)
  );

  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_ERR);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = (state_q == ST_ERR);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o || err_o);

  assert_err_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !bus_rd_o && !bus_wr_o);

  assert_poll_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_POLL && ack && rbit |=> state_q != ST_LOCK1);

  assert_lock_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOCK1 && !lock_i |=> state_q != ST_FB_EXT);
endmodule

// File: tb/pll_recal_seq_test.sv
module pll_recal_seq_test;
  localparam int AW = 12, DW = 32, TW = 16;
  localparam int NEVER = 1000000;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, lock = 1'b1, bwait = 1'b0;
  logic [TW-1:0] limit = 16'd100;
  logic [DW-1:0] brdata = '0;
  logic [AW-1:0] baddr;
  logic          brd, bwr, busy, done, err;
  logic [DW-1:0] bwdata;

  always #2 clk = ~clk;

  pll_recal_seq #(.ADDR_W(AW), .DATA_W(DW), .TMO_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tmo_limit_i(limit), .lock_i(lock),
    .bus_addr_o(baddr), .bus_rd_o(brd), .bus_wr_o(bwr), .bus_wdata_o(bwdata),
    .bus_rdata_i(brdata), .bus_wait_i(bwait),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int n_tests = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // slave / PLL model state
  logic [DW-1:0] mem [int];
  int            wa[$];
  logic [DW-1:0] wd[$];
  int stat_reads, rmw_reads, fb_writes, fb_reads, cmd_cycles, done_cnt;
  int cal_left, cal_polls, stall_cfg, waited, lock_cnt, ld1, ld2, cyc;
  int lock_rise1, lock_rise2, fb2_rd_cyc, done_cyc;
  logic p_cmd = 0, p_wait = 0, p_rd = 0, p_wr = 0, p_busy = 0, p_done = 0, p_start = 0, p_rst = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_wdata = '0;

  initial begin
    cal_left = 0; stall_cfg = 0; waited = 0; lock_cnt = 0; cyc = 0; done_cnt = 0;
    cal_polls = 0; ld1 = 0; ld2 = 0;
  end

  always @(negedge clk) begin
    logic cmd, nw;
    cyc++;
    cmd = brd || bwr;
    if (rst_n && p_rst) begin
      if (p_cmd && p_wait)
        check(baddr == p_addr && brd == p_rd && bwr == p_wr && (!bwr || bwdata == p_wdata),
              "R8 hold", {brd, bwr, baddr}, {p_rd, p_wr, p_addr});
      check(busy == ((p_start && !p_busy) || (p_busy && !p_done && !err)), "R9 busy",
            busy, (p_start && !p_busy) || (p_busy && !p_done && !err));
      check(!(brd && bwr), "R7 one command", {brd, bwr}, 2'b00);
    end
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (cmd) cmd_cycles++;
    nw = 1'b0;
    if (cmd) begin
      if (waited < stall_cfg) begin nw = 1'b1; waited++; end
      else waited = 0;
    end
    if (brd) begin
      if (int'(baddr) == 'h280) brdata = {{(DW-2){1'b0}}, (cal_left > 0), 1'b0};
      else brdata = mem.exists(int'(baddr)) ? mem[int'(baddr)] : '0;
    end
    if (!lock) begin
      if (lock_cnt == 0) begin
        lock = 1'b1;
        if (fb_writes == 1) lock_rise1 = cyc; else lock_rise2 = cyc;
      end else lock_cnt--;
    end
    if (cmd && !nw) begin
      if (brd && int'(baddr) == 'h280) begin
        stat_reads++;
        if (cal_left > 0) cal_left--;
      end else if (brd) begin
        rmw_reads++;
        if (int'(baddr) == 'h126) begin
          fb_reads++;
          if (fb_reads == 2) fb2_rd_cyc = cyc;
        end
      end
      if (bwr) begin
        wa.push_back(int'(baddr));
        wd.push_back(bwdata);
        mem[int'(baddr)] = bwdata;
        if (int'(baddr) == 0 && bwdata[0]) cal_left = cal_polls;
        if (int'(baddr) == 'h126) begin
          fb_writes++;
          lock = 1'b0;
          lock_cnt = (fb_writes == 1) ? ld1 : ld2;
        end
      end
    end
    bwait = nw;
    p_cmd = cmd; p_wait = nw; p_rd = brd; p_wr = bwr; p_addr = baddr; p_wdata = bwdata;
    p_busy = busy; p_done = done; p_start = start; p_rst = rst_n;
  end

  task automatic setup(input logic [DW-1:0] f, input logic [DW-1:0] q, input logic [DW-1:0] g,
                       input int st, input int pl, input int l1, input int l2, input int lim);
    mem['h126] = f; mem['h100] = q; mem['h000] = g;
    wa.delete(); wd.delete();
    stat_reads = 0; rmw_reads = 0; fb_writes = 0; fb_reads = 0; cmd_cycles = 0;
    done_cnt = 0; lock_rise1 = 0; lock_rise2 = 0; fb2_rd_cyc = 0; done_cyc = 0;
    stall_cfg = st; cal_polls = pl; ld1 = l1; ld2 = l2; limit = TW'(lim);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_end(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (done_cnt != 0 || err) return;
    end
    check(1'b0, "watchdog", 0, 1);
  endtask

  task automatic verify_writes(input logic [DW-1:0] f, input logic [DW-1:0] q, input logic [DW-1:0] g);
    check(wa.size() == 4, "R7 write count", wa.size(), 4);
    if (wa.size() == 4) begin
      check(wa[0] == 'h126 && wd[0] == (f | 1), "R1 internal feedback write", wd[0], f | 1);
      check(wa[1] == 'h100 && wd[1] == (q | 1), "R2 request write", {wa[1], wd[1]}, {32'h100, q | 1});
      check(wa[2] == 'h000 && wd[2] == (g | 1), "R2 go write", {wa[2], wd[2]}, {32'h0, g | 1});
      check(wa[3] == 'h126 && wd[3] == (f & ~32'd1), "R5 external feedback write", wd[3], f & ~32'd1);
    end
  endtask

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    check({busy, done, err, brd, bwr} == 5'b0, "R11 reset outputs", {busy, done, err, brd, bwr}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, err, brd, bwr} == 5'b0, "R11 idle after reset", {busy, done, err, brd, bwr}, 0);

    // T1: plain run, no stalls
    setup(32'h0000A5A4, 32'h10, 32'h80, 0, 2, 3, 4, 100);
    pulse_start();
    wait_end(2000);
    check(done_cnt == 1 && !err, "R6 done reached", {done_cnt, err}, 1 << 1);
    verify_writes(32'h0000A5A4, 32'h10, 32'h80);
    check(stat_reads == 3, "R3 poll count", stat_reads, 3);
    check(rmw_reads == 4, "R7 rmw reads", rmw_reads, 4);
    check(fb2_rd_cyc > lock_rise1, "R4 lock before switch-back", fb2_rd_cyc, lock_rise1 + 1);
    check(done_cyc > lock_rise2, "R6 lock before done", done_cyc, lock_rise2 + 1);
    @(negedge clk);
    check(!busy && !done, "R6 single pulse, idle", {busy, done}, 0);

    // T2: stalls, bit already set, late lock, extra start mid-run
    setup(32'h000000FF, 32'h0, 32'h0, 2, 0, 30, 10, 200);
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_end(3000);
    repeat (30) @(negedge clk);
    check(done_cnt == 1, "R9 extra start ignored", done_cnt, 1);
    check(!busy, "R9 idle after run", busy, 0);
    verify_writes(32'h000000FF, 32'h0, 32'h0);
    check(stat_reads == 1, "R3 single poll", stat_reads, 1);
    check(fb2_rd_cyc > lock_rise1, "R4 late lock gates switch-back", fb2_rd_cyc, lock_rise1 + 1);

    // T3: calibration never finishes
    setup(32'h00001230, 32'h4, 32'h2, 1, NEVER, 2, 2, 20);
    pulse_start();
    wait_end(3000);
    check(err && !busy, "R10 poll timeout", {err, busy}, 2'b10);
    check(wa.size() == 3, "R10 no switch-back after timeout", wa.size(), 3);
    c0 = cmd_cycles;
    repeat (20) @(negedge clk);
    check(cmd_cycles == c0 && err, "R10 bus quiet in error", cmd_cycles - c0, 0);

    // T4: restart from error
    setup(32'h00001230, 32'h4, 32'h2, 0, 1, 2, 2, 50);
    pulse_start();
    @(negedge clk);
    check(!err && busy, "R10 start clears error", {err, busy}, 2'b01);
    wait_end(2000);
    check(done_cnt == 1 && !err, "R10 recovered run", done_cnt, 1);
    verify_writes(32'h00001231, 32'h5, 32'h3);

    // T5: lock lost after switch-back
    setup(32'h00000010, 32'h0, 32'h0, 0, 0, 1, NEVER, 15);
    pulse_start();
    wait_end(2000);
    check(err && done_cnt == 0, "R10 lock timeout", {err, done_cnt}, 1 << 32);
    check(wa.size() == 4, "R10 four writes before lock timeout", wa.size(), 4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule